// File: doc/BRIEF.md
# LIN Physical-Layer Mode Sequencer

This block is the digital control core of a LIN bus node interface that has its own supply regulator. It watches battery and regulator supply flags, the enable and transmit-data pins from the host microcontroller, a remote wake-up request from the bus receiver, and any external pull on the active-low reset line. From these it chooses one of five operating modes: off, fail-safe, normal, silent or sleep. It also passes through a short mode-select state. In each mode it drives the regulator enable, the transmit and receive path enables, the active-low reset output and, while in fail-safe, a two-bit cause code on the transmit and receive data pins.

The host chooses a low-power mode by dropping the enable pin. The level on the transmit-data pin at the end of a short window after that falling edge picks the mode: high selects silent, low selects sleep. Because of this window, the enable pin may fall a few cycles before the transmit-data pin. Every pin and flag input passes through a two-flop synchroniser before the block acts on it. The reset line is both an output and an input. A reset hold is started on power-up, on regulator undervoltage and on a wake-up from sleep. Any low level on the line, whether from that hold or from an external pull, keeps the block out of normal mode.

Top module: `lin_mode_ctrl`

## Requirements
- R1: After reset the mode output is 0 (off), with regulator off, reset output low, both paths disabled, transmit-data output-enable low, and both pin outputs at 1.
- R2: With battery above the power-up threshold in off mode, the block enters fail-safe (mode code 1). In fail-safe the regulator is on, both paths are disabled and the transmit-data output-enable is high. The cause is shown with the transmit-data pin as bit 1 and the receive-data pin as bit 0: power-up is 11, undervoltage 10, wake-up 01 and reset line 00.
- R3: On power-up entry, undervoltage entry or wake-up from sleep, the reset output is held low for exactly HOLD_CYC cycles from the cycle in which fail-safe is entered.
- R4: In fail-safe, the block moves to normal (mode code 2) when the enable pin is high and the reset line is high. Normal enables both paths with the reset output high. The block stays in fail-safe while the reset hold is running.
- R5: An enable falling edge in normal mode, with transmit-data high at the end of the window, leads to silent (mode code 4). Silent has transmit disabled, receive enabled and the regulator on.
- R6: The same edge with transmit-data low leads to sleep (mode code 5). Sleep has the regulator, both paths and the reset output off. The enable pin is ignored in sleep.
- R7: Transmit-data is sampled SEL_WIN cycles after the falling edge, so it may fall a few cycles after the enable pin and still select sleep.
- R8: A regulator undervoltage flag in normal mode forces fail-safe with cause 10 and starts the reset hold.
- R9: A low external reset line in normal or silent mode forces fail-safe with cause 00. While the line stays low, the block does not enter normal.
- R10: Battery below the lower threshold forces off mode from any mode. This takes priority over every other input.
- R11: A wake-up request in silent or sleep forces fail-safe with cause 01. It starts the reset hold only when it comes from sleep. A wake-up request in normal is ignored.
- R12: A high enable pin in silent mode returns the block to normal.
- R13: During the select window (mode code 3) transmit is disabled. If the enable pin rises again within the window, the block returns to normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low logic reset |
| vbat_up_i | input | 1 | Battery above power-up threshold |
| vbat_low_i | input | 1 | Battery below lower threshold |
| vreg_uv_i | input | 1 | Regulator output undervoltage |
| en_i | input | 1 | Enable pin from host |
| txd_i | input | 1 | Transmit-data pin level |
| rst_ext_n_i | input | 1 | External level on the reset line (low = pulled down) |
| wake_i | input | 1 | Remote wake-up request |
| rstn_o | output | 1 | Active-low reset drive |
| reg_on_o | output | 1 | Regulator enable |
| tx_en_o | output | 1 | Transmit path enable |
| rx_en_o | output | 1 | Receive path enable |
| txd_oe_o | output | 1 | Transmit-data pin driven as output |
| txd_o | output | 1 | Transmit-data pin drive value (cause bit 1 in fail-safe) |
| rxd_o | output | 1 | Receive-data pin cause bit 0 in fail-safe, else 1 |
| mode_o | output | 3 | Current mode code |

## Verification
The mode-select decision is driven three ways. In the first, transmit-data is held high as enable falls, which gives silent. In the second, transmit-data drops a cycle after enable, which gives sleep and shows that sampling happens late in the window. In the third, enable rises again inside the window, which aborts the select and returns to normal. Entries into fail-safe are provoked by power-up, undervoltage, an external reset pull, and wake-up from silent and from sleep. Each of these is identified by its cause code and by whether the reset hold restarts. A wake-up in normal and an enable pulse in sleep show that these inputs are ignored. Low battery is applied together with undervoltage to show that it takes priority.

// File: rtl/lin_mode_pkg.sv
package lin_mode_pkg;

    typedef enum logic [2:0] {
        MD_OFF    = 3'd0,
        MD_FSAFE  = 3'd1,
        MD_NORM   = 3'd2,
        MD_SEL    = 3'd3,
        MD_SILENT = 3'd4,
        MD_SLEEP  = 3'd5
    } lin_mode_e;

    // bit 1 goes to the transmit-data pin, bit 0 to the receive-data pin
    typedef enum logic [1:0] {
        FS_RSTLINE = 2'b00,
        FS_WAKE    = 2'b01,
        FS_UNDERV  = 2'b10,
        FS_POWER   = 2'b11
    } fs_cause_e;

    typedef struct packed {
        logic vbat_up;
        logic vbat_low;
        logic vreg_uv;
        logic en;
        logic txd;
        logic rst_ext_n;
        logic wake;
    } pin_vec_t;

    localparam int PIN_W = $bits(pin_vec_t);
    // idle levels: supplies absent, enable low, data and reset line high
    localparam logic [PIN_W-1:0] PIN_IDLE = 7'b000_0110;

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int              W    = 1,
    parameter logic [W-1:0]    INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{s1: INIT, s2: INIT};
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o = st_q.s2;

endmodule

// File: rtl/hold_timer.sv
module hold_timer #(
    parameter int HOLD_CYC = 800000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic clear_i,
    output logic busy_o
);

    localparam int CW = $clog2(HOLD_CYC + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (start_i) begin
            cnt_d = CW'(HOLD_CYC);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign busy_o = (cnt_q != '0);

endmodule

// File: rtl/mode_fsm.sv
module mode_fsm
    import lin_mode_pkg::*;
#(
    parameter int SEL_WIN = 640
) (
    input  logic      clk,
    input  logic      rst_n,
    input  pin_vec_t  pins_i,
    input  logic      line_ok_i,
    output lin_mode_e mode_o,
    output fs_cause_e cause_o,
    output logic      hold_start_o,
    output logic      hold_clear_o
);

    localparam int WW = $clog2(SEL_WIN + 1);

    typedef struct packed {
        lin_mode_e      mode;
        fs_cause_e      cause;
        logic           en_prev;
        logic [WW-1:0]  win;
    } fsm_st_t;

    fsm_st_t st_d, st_q;
    logic    en_fall;
    logic    start_d;

    always_comb begin
        st_d         = st_q;
        start_d      = 1'b0;
        en_fall      = st_q.en_prev & ~pins_i.en;
        st_d.en_prev = pins_i.en;

        if (pins_i.vbat_low) begin
            st_d.mode = MD_OFF;
        end else begin
            unique case (st_q.mode)
                MD_OFF: begin
                    if (pins_i.vbat_up) begin
                        st_d.mode  = MD_FSAFE;
                        st_d.cause = FS_POWER;
                        start_d    = 1'b1;
                    end
                end
                MD_FSAFE: begin
                    if (pins_i.en && line_ok_i) begin
                        st_d.mode = MD_NORM;
                    end
                end
                MD_NORM, MD_SEL: begin
                    if (pins_i.vreg_uv) begin
                        st_d.mode  = MD_FSAFE;
                        st_d.cause = FS_UNDERV;
                        start_d    = 1'b1;
                    end else if (!line_ok_i) begin
                        st_d.mode  = MD_FSAFE;
                        st_d.cause = FS_RSTLINE;
                    end else if (st_q.mode == MD_NORM) begin
                        if (en_fall) begin
                            st_d.mode = MD_SEL;
                            st_d.win  = WW'(SEL_WIN);
                        end
                    end else if (pins_i.en) begin
                        st_d.mode = MD_NORM;
                    end else if (st_q.win <= WW'(1)) begin
                        st_d.mode = pins_i.txd ? MD_SILENT : MD_SLEEP;
                        st_d.win  = '0;
                    end else begin
                        st_d.win = st_q.win - WW'(1);
                    end
                end
                MD_SILENT: begin
                    if (!line_ok_i) begin
                        st_d.mode  = MD_FSAFE;
                        st_d.cause = FS_RSTLINE;
                    end else if (pins_i.wake) begin
                        st_d.mode  = MD_FSAFE;
                        st_d.cause = FS_WAKE;
                    end else if (pins_i.en) begin
                        st_d.mode = MD_NORM;
                    end
                end
                MD_SLEEP: begin
                    if (pins_i.wake) begin
                        st_d.mode  = MD_FSAFE;
                        st_d.cause = FS_WAKE;
                        start_d    = 1'b1;
                    end
                end
                default: begin
                    st_d.mode = MD_OFF;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MD_OFF, cause: FS_POWER, en_prev: 1'b0, win: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o       = st_q.mode;
    assign cause_o      = st_q.cause;
    assign hold_start_o = start_d;
    assign hold_clear_o = pins_i.vbat_low;

endmodule

// File: rtl/lin_mode_ctrl.sv
module lin_mode_ctrl
    import lin_mode_pkg::*;
#(
    parameter int HOLD_CYC = 800000,
    parameter int SEL_WIN  = 640
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vbat_up_i,
    input  logic       vbat_low_i,
    input  logic       vreg_uv_i,
    input  logic       en_i,
    input  logic       txd_i,
    input  logic       rst_ext_n_i,
    input  logic       wake_i,
    output logic       rstn_o,
    output logic       reg_on_o,
    output logic       tx_en_o,
    output logic       rx_en_o,
    output logic       txd_oe_o,
    output logic       txd_o,
    output logic       rxd_o,
    output logic [2:0] mode_o
);

    pin_vec_t  raw;
    pin_vec_t  pins;
    lin_mode_e mode;
    fs_cause_e cause;
    logic      hold_start, hold_clear, hold_busy;
    logic      line_ok;

    assign raw = '{vbat_up: vbat_up_i, vbat_low: vbat_low_i, vreg_uv: vreg_uv_i,
                   en: en_i, txd: txd_i, rst_ext_n: rst_ext_n_i, wake: wake_i};

    pin_sync #(
        .W    (PIN_W),
        .INIT (PIN_IDLE)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw),
        .q_o   (pins)
    );

    hold_timer #(
        .HOLD_CYC (HOLD_CYC)
    ) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (hold_start),
        .clear_i (hold_clear),
        .busy_o  (hold_busy)
    );

    mode_fsm #(
        .SEL_WIN (SEL_WIN)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .pins_i       (pins),
        .line_ok_i    (line_ok),
        .mode_o       (mode),
        .cause_o      (cause),
        .hold_start_o (hold_start),
        .hold_clear_o (hold_clear)
    );

    always_comb begin
        rstn_o   = !hold_busy && (mode != MD_OFF) && (mode != MD_SLEEP);
        reg_on_o = (mode != MD_OFF) && (mode != MD_SLEEP);
        tx_en_o  = (mode == MD_NORM);
        rx_en_o  = (mode == MD_NORM) || (mode == MD_SEL) || (mode == MD_SILENT);
        txd_oe_o = (mode == MD_FSAFE);
        txd_o    = (mode == MD_FSAFE) ? cause[1] : 1'b1;
        rxd_o    = (mode == MD_FSAFE) ? cause[0] : 1'b1;
    end

    // the shared reset line is low if this block or anything outside pulls it
    assign line_ok = rstn_o & pins.rst_ext_n;
    assign mode_o  = mode;

endmodule

// File: rtl/lin_mode_ctrl_chk.sv
module lin_mode_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       vbat_low_i,
    input logic       rstn_o,
    input logic       reg_on_o,
    input logic       tx_en_o,
    input logic       rx_en_o,
    input logic       txd_oe_o,
    input logic [2:0] mode_o
);

    p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd0) |-> (!reg_on_o && !rstn_o && !tx_en_o && !rx_en_o));

    p_fsafe_pins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd1) |-> (txd_oe_o && reg_on_o && !tx_en_o && !rx_en_o));

    p_entry_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd1 && $past(mode_o) == 3'd0) |-> !rstn_o);

    p_normal_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd2) |-> (rstn_o && tx_en_o && rx_en_o && !txd_oe_o));

    p_silent_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd4) |-> (!tx_en_o && rx_en_o && reg_on_o));

    p_sleep_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd5) |-> (!reg_on_o && !tx_en_o && !rx_en_o && !rstn_o));

    p_lowbat_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (vbat_low_i && $past(vbat_low_i) && $past(vbat_low_i, 2)) |=> (mode_o == 3'd0));

    p_tx_only_normal_r13: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en_o |-> (mode_o == 3'd2));

endmodule

bind lin_mode_ctrl lin_mode_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .vbat_low_i (vbat_low_i),
    .rstn_o     (rstn_o),
    .reg_on_o   (reg_on_o),
    .tx_en_o    (tx_en_o),
    .rx_en_o    (rx_en_o),
    .txd_oe_o   (txd_oe_o),
    .mode_o     (mode_o)
);

// File: tb/lin_mode_ctrl_test.sv
`timescale 1ns/1ps
module lin_mode_ctrl_test;

    localparam int HOLD = 20;
    localparam int WIN  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vbat_up = 0, vbat_low = 0, vreg_uv = 0, en = 0, txd = 1, rst_ext_n = 1, wake = 0;
    logic rstn_o, reg_on_o, tx_en_o, rx_en_o, txd_oe_o, txd_o, rxd_o;
    logic [2:0] mode_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    typedef struct {
        string      tag;
        logic [9:0] v;
    } item_t;

    item_t sb[$];

    always #2.5 clk = ~clk;

    lin_mode_ctrl #(.HOLD_CYC(HOLD), .SEL_WIN(WIN)) uut (
        .clk(clk), .rst_n(rst_n),
        .vbat_up_i(vbat_up), .vbat_low_i(vbat_low), .vreg_uv_i(vreg_uv),
        .en_i(en), .txd_i(txd), .rst_ext_n_i(rst_ext_n), .wake_i(wake),
        .rstn_o(rstn_o), .reg_on_o(reg_on_o), .tx_en_o(tx_en_o), .rx_en_o(rx_en_o),
        .txd_oe_o(txd_oe_o), .txd_o(txd_o), .rxd_o(rxd_o), .mode_o(mode_o)
    );

    function automatic logic [9:0] snap();
        return {mode_o, reg_on_o, rstn_o, tx_en_o, rx_en_o, txd_oe_o, txd_o, rxd_o};
    endfunction

    function automatic void cmp(string tag, logic [9:0] exp);
        n_tests++;
        if (snap() !== exp) begin
            n_fail++;
            $display("FAIL %s: got mode/reg/rstn/tx/rx/oe/txd/rxd=%b expected %b", tag, snap(), exp);
        end
    endfunction

    function automatic void chk_int(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endfunction

    // monitor: compares queued expectations on the falling edge
    always @(negedge clk) begin
        if (sb.size() != 0) begin
            item_t it;
            it = sb.pop_front();
            cmp(it.tag, it.v);
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    // driver side: queue the expected outputs after the next rising edge
    task automatic expect_out(string tag, logic [2:0] m, bit rg, bit rs, bit tx, bit rx,
                              bit oe, bit td, bit rd);
        @(posedge clk);
        #1;
        sb.push_back('{tag, {m, rg, rs, tx, rx, oe, td, rd}});
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int  n;
        bit  left;
        step(3);
        rst_n = 1'b1;
        step(2);
        expect_out("R1 reset state", 3'd0, 0, 0, 0, 0, 0, 1, 1);

        // power-up with enable already high: hold must block normal
        en = 1'b1;
        vbat_up = 1'b1;
        n = 0;
        while (mode_o != 3'd1 && n < 50) begin
            n++;
            step(1);
        end
        cmp("R2 fail-safe after power-up, cause 11", {3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1});
        n = 0;
        left = 0;
        while (!rstn_o && n < 1000) begin
            if (mode_o != 3'd1) left = 1;
            n++;
            step(1);
        end
        chk_int("R3 reset hold length", n, HOLD);
        chk_int("R4 stays fail-safe while hold runs", int'(left), 0);
        step(2);
        expect_out("R4 normal after hold with enable high", 3'd2, 1, 1, 1, 1, 0, 1, 1);

        // silent selection, wake from silent
        txd = 1'b1;
        en = 1'b0;
        step(10);
        expect_out("R5 silent with txd high", 3'd4, 1, 1, 0, 1, 0, 1, 1);
        wake = 1'b1;
        step(4);
        wake = 1'b0;
        expect_out("R11 wake in silent, cause 01, no hold", 3'd1, 1, 1, 0, 0, 1, 0, 1);
        en = 1'b1;
        step(5);
        expect_out("R4 normal again", 3'd2, 1, 1, 1, 1, 0, 1, 1);

        wake = 1'b1;
        step(5);
        expect_out("R11 wake ignored in normal", 3'd2, 1, 1, 1, 1, 0, 1, 1);
        wake = 1'b0;

        // aborted select
        en = 1'b0;
        step(3);
        expect_out("R13 select window, tx off", 3'd3, 1, 1, 0, 1, 0, 1, 1);
        en = 1'b1;
        step(5);
        expect_out("R13 enable back high aborts select", 3'd2, 1, 1, 1, 1, 0, 1, 1);

        // late txd fall selects sleep
        en = 1'b0;
        step(1);
        txd = 1'b0;
        step(10);
        expect_out("R7 late txd fall gives sleep", 3'd5, 0, 0, 0, 0, 0, 1, 1);
        en = 1'b1;
        step(5);
        expect_out("R6 enable ignored in sleep", 3'd5, 0, 0, 0, 0, 0, 1, 1);
        txd = 1'b1;
        wake = 1'b1;
        step(4);
        wake = 1'b0;
        expect_out("R11 wake from sleep, cause 01, hold", 3'd1, 1, 0, 0, 0, 1, 0, 1);
        step(HOLD + 6);
        expect_out("R4 normal after wake hold", 3'd2, 1, 1, 1, 1, 0, 1, 1);

        // undervoltage
        vreg_uv = 1'b1;
        step(4);
        vreg_uv = 1'b0;
        expect_out("R8 undervoltage, cause 10, hold", 3'd1, 1, 0, 0, 0, 1, 1, 0);
        step(HOLD + 6);
        expect_out("R8 recovers to normal", 3'd2, 1, 1, 1, 1, 0, 1, 1);

        // external reset pull in normal
        rst_ext_n = 1'b0;
        step(4);
        expect_out("R9 external reset in normal, cause 00", 3'd1, 1, 1, 0, 0, 1, 0, 0);
        step(5);
        expect_out("R9 held low blocks normal", 3'd1, 1, 1, 0, 0, 1, 0, 0);
        rst_ext_n = 1'b1;
        step(5);
        expect_out("R9 release returns to normal", 3'd2, 1, 1, 1, 1, 0, 1, 1);

        // external reset pull in silent
        en = 1'b0;
        step(10);
        expect_out("R5 silent again", 3'd4, 1, 1, 0, 1, 0, 1, 1);
        rst_ext_n = 1'b0;
        step(4);
        rst_ext_n = 1'b1;
        expect_out("R9 external reset in silent, cause 00", 3'd1, 1, 1, 0, 0, 1, 0, 0);

        // enable high in silent
        en = 1'b1;
        step(5);
        en = 1'b0;
        step(10);
        expect_out("R12 silent before enable", 3'd4, 1, 1, 0, 1, 0, 1, 1);
        en = 1'b1;
        step(5);
        expect_out("R12 enable high leaves silent", 3'd2, 1, 1, 1, 1, 0, 1, 1);

        // low battery beats undervoltage
        vbat_low = 1'b1;
        vreg_uv = 1'b1;
        step(5);
        expect_out("R10 low battery forces off", 3'd0, 0, 0, 0, 0, 0, 1, 1);
        vbat_low = 1'b0;
        vreg_uv = 1'b0;
        step(5);
        expect_out("R2 power-up again, cause 11", 3'd1, 1, 0, 0, 0, 1, 1, 1);

        step(2);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule